// File: doc/BRIEF.md
# Bus Line-Condition Monitor and Control Register

This block is a byte-wide control and status register for a peripheral that can act as a low-speed USB device or as a PS/2 device. Firmware writes it to turn on the PS/2 pull-ups and the 3.3 V regulator, to pick which line condition raises the bus interrupt, and to force the D+ and D− pins. Firmware reads it back to see whether the serial interface engine has reported bus traffic since the last clear.

A persistence detector runs beside the register. It watches one of two conditions. In USB mode the condition is single-ended zero, with both D+ and D− low. In PS/2 mode the condition is the PS/2 data line held low. A free-running tick of `TICK_CYCLES` clocks, which corresponds to 128 µs in the target system, quantizes the watch. The interrupt fires once the condition has been seen at two successive ticks with no break between them, so the persistence it demands lies between one and two tick periods.

The activity flag is sticky. Only the serial interface engine's strobe can set it, and only a firmware write of zero can clear it.

Top module: `busStatusReg`

## Requirements
- R1: After reset, `rdData` reads 0x00 and `pullupEn`, `vregEn`, `ppForce`, `openDrain`, `dpLevel`, `dmLevel` and `busIrq` are all 0. Mode 0 (USB) is therefore the default.
- R2: A write stores bits 7, 6, 5 and 2:0 of `wrData`, and `rdData` returns them on the cycle after the write. Bit 7 drives `pullupEn`, bit 6 drives `vregEn` and bit 5 is the mode bit (0 = USB single-ended zero, 1 = PS/2 data low).
- R3: Bit 4 always reads 0, whatever value is written to it.
- R4: A one-cycle pulse on `activityStb` sets bit 3. The bit then stays 1 with no further strobe.
- R5: A write with bit 3 = 0 clears the activity bit. A write with bit 3 = 1 leaves it unchanged, whether it is 0 or 1.
- R6: When `activityStb` and a write with bit 3 = 0 occur in the same cycle, bit 3 ends up at 1.
- R7: In mode 0, holding `dpIn`=0 and `dmIn`=0 long enough raises `busIrq`. Any other D+/D− pattern never raises it, and `ps2DataIn` has no effect.
- R8: In mode 1, holding `ps2DataIn`=0 long enough raises `busIrq`. `dpIn` and `dmIn` have no effect.
- R9: Count posedges from the clock period in which a qualifying condition is first driven on the pins. `busIrq` is first seen high after posedge L, with TICK_CYCLES+3 ≤ L ≤ 2·TICK_CYCLES+2. This window includes the two-flop input synchronizer. A condition held for at most TICK_CYCLES clock periods never raises `busIrq`.
- R10: `busIrq` is a single-cycle pulse. It fires once per continuous condition, however long the condition lasts. It fires again only after the condition has gone away and then qualified afresh.
- R11: Pin forcing works as follows. With bit 2 = 1, `openDrain`=1, `ppForce`=0, `dpLevel`=bit 0 and `dmLevel`=bit 1. With bit 2 = 0, `openDrain`=0 and bits 1:0 select the push-pull state: 00 means not forced (`ppForce`=0, both levels 0), 01 gives D+ high and D− low, 10 gives D+ low and D− high, and 11 gives both low. In the last three cases `ppForce`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read value |
| activityStb | input | 1 | Bus-activity pulse from the serial interface engine |
| dpIn | input | 1 | D+ line level (asynchronous) |
| dmIn | input | 1 | D− line level (asynchronous) |
| ps2DataIn | input | 1 | PS/2 data line level (asynchronous) |
| pullupEn | output | 1 | PS/2 pull-up enable |
| vregEn | output | 1 | Regulator enable |
| ppForce | output | 1 | Push-pull pin forcing active |
| openDrain | output | 1 | Pins in open-drain mode |
| dpLevel | output | 1 | Forced D+ level |
| dmLevel | output | 1 | Forced D− level |
| busIrq | output | 1 | Single-cycle line-condition interrupt |

## Verification
Two functions can land in the same cycle: the engine's activity strobe setting bit 3, and a firmware write clearing it. The bench drives the strobe and a write of zero in the same clock period, both when the bit starts at 0 and when it starts at 1, and reads back to confirm that the set won. The detector is swept over every line pattern in both modes while the start offset shifts against the tick phase. Each run is judged by its pulse count and by a first-pulse latency that must fall inside the quantized window.

// File: rtl/bsrPkg.sv
package bsrPkg;
  localparam int PULLUP_BIT = 7;
  localparam int VREG_BIT   = 6;
  localparam int MODE_BIT   = 5;
  localparam int RSVD_BIT   = 4;
  localparam int ACT_BIT    = 3;
  localparam int FORCE_HI   = 2;

  typedef struct packed {
    logic cfgWr;   // store the configuration fields
    logic actSet;  // hardware set of the activity flag
    logic actClr;  // firmware clear of the activity flag
  } strobeT;
endpackage

// File: rtl/bsrCtrl.sv
module bsrCtrl
  import bsrPkg::*;
(
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       activityStb,
  output strobeT     stb
);
  always_comb begin
    stb.cfgWr  = wrEn;
    stb.actSet = activityStb;
    // set has priority: a clear is suppressed when the strobe is present
    stb.actClr = wrEn && !wrData[ACT_BIT] && !activityStb;
  end
endmodule

// File: rtl/bsrDetector.sv
module bsrDetector #(
  parameter int TICK_CYCLES = 1536,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic psMode,
  input  logic dpIn,
  input  logic dmIn,
  input  logic ps2In,
  output logic irqPulse
);
  localparam int TW        = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam int LINES     = 3;
  localparam logic [TW-1:0] TICK_LAST = TW'(TICK_CYCLES - 1);

  logic [LINES-1:0] syncReg [SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) syncReg[0] <= '1;
    else       syncReg[0] <= {ps2In, dmIn, dpIn};
  end

  generate
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : gSync
      always_ff @(posedge clk) begin
        if (!rstN) syncReg[s] <= '1;
        else       syncReg[s] <= syncReg[s-1];
      end
    end
  endgenerate

  logic [LINES-1:0] lineNow;
  logic             cond;
  assign lineNow = syncReg[SYNC_STAGES-1];
  assign cond    = psMode ? !lineNow[2] : (!lineNow[0] && !lineNow[1]);

  logic [TW-1:0] tickCnt;
  logic          tick;
  assign tick = (tickCnt == TICK_LAST);

  always_ff @(posedge clk) begin
    if (!rstN)     tickCnt <= '0;
    else if (tick) tickCnt <= '0;
    else           tickCnt <= tickCnt + 1'b1;
  end

  logic [1:0] qual;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      qual     <= 2'd0;
      irqPulse <= 1'b0;
    end else begin
      irqPulse <= cond && tick && (qual == 2'd1);
      if (!cond)                      qual <= 2'd0;
      else if (tick && qual != 2'd2)  qual <= qual + 2'd1;
    end
  end

  // R10
  irq_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

  // R9
  irq_qual_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> qual == 2'd2);
endmodule

// File: rtl/bsrDatapath.sv
module bsrDatapath
  import bsrPkg::*;
#(
  parameter int TICK_CYCLES = 1536
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobeT     stb,
  input  logic [7:0] cfgData,
  input  logic       dpIn,
  input  logic       dmIn,
  input  logic       ps2In,
  output logic [7:0] regOut,
  output logic       pullupEn,
  output logic       vregEn,
  output logic       ppForce,
  output logic       openDrain,
  output logic       dpLevel,
  output logic       dmLevel,
  output logic       irqPulse
);
  logic       pullupQ, vregQ, modeQ, actQ;
  logic [2:0] forceQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pullupQ <= 1'b0;
      vregQ   <= 1'b0;
      modeQ   <= 1'b0;
      forceQ  <= 3'b000;
    end else if (stb.cfgWr) begin
      pullupQ <= cfgData[PULLUP_BIT];
      vregQ   <= cfgData[VREG_BIT];
      modeQ   <= cfgData[MODE_BIT];
      forceQ  <= cfgData[FORCE_HI:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           actQ <= 1'b0;
    else if (stb.actSet) actQ <= 1'b1;
    else if (stb.actClr) actQ <= 1'b0;
  end

  always_comb begin
    regOut             = '0;
    regOut[PULLUP_BIT] = pullupQ;
    regOut[VREG_BIT]   = vregQ;
    regOut[MODE_BIT]   = modeQ;
    regOut[ACT_BIT]    = actQ;
    regOut[FORCE_HI:0] = forceQ;
  end

  assign pullupEn  = pullupQ;
  assign vregEn    = vregQ;
  assign openDrain = forceQ[2];
  assign ppForce   = !forceQ[2] && (forceQ[1:0] != 2'b00);
  assign dpLevel   = forceQ[2] ? forceQ[0] : (forceQ[1:0] == 2'b01);
  assign dmLevel   = forceQ[2] ? forceQ[1] : (forceQ[1:0] == 2'b10);

  bsrDetector #(.TICK_CYCLES(TICK_CYCLES), .SYNC_STAGES(2)) uDet (
    .clk(clk), .rstN(rstN), .psMode(modeQ),
    .dpIn(dpIn), .dmIn(dmIn), .ps2In(ps2In), .irqPulse(irqPulse)
  );

  // R4
  act_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.actSet |=> regOut[ACT_BIT]);

  // R5
  act_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.actClr |=> !regOut[ACT_BIT]);

  // R5
  act_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.actSet && !stb.actClr) |=> $stable(regOut[ACT_BIT]));

  // R11
  force_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ppForce && openDrain));
endmodule

// File: rtl/busStatusReg.sv
module busStatusReg
  import bsrPkg::*;
#(
  parameter int TICK_CYCLES = 1536
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       activityStb,
  input  logic       dpIn,
  input  logic       dmIn,
  input  logic       ps2DataIn,
  output logic       pullupEn,
  output logic       vregEn,
  output logic       ppForce,
  output logic       openDrain,
  output logic       dpLevel,
  output logic       dmLevel,
  output logic       busIrq
);
  strobeT stb;

  bsrCtrl uCtrl (
    .wrEn(wrEn), .wrData(wrData), .activityStb(activityStb), .stb(stb)
  );

  bsrDatapath #(.TICK_CYCLES(TICK_CYCLES)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgData(wrData),
    .dpIn(dpIn), .dmIn(dmIn), .ps2In(ps2DataIn),
    .regOut(rdData), .pullupEn(pullupEn), .vregEn(vregEn),
    .ppForce(ppForce), .openDrain(openDrain),
    .dpLevel(dpLevel), .dmLevel(dmLevel), .irqPulse(busIrq)
  );
endmodule

// File: tb/tb_busStatusReg.sv
module tb_busStatusReg;
  localparam int TICK = 8;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, activityStb = 1'b0;
  logic [7:0] wrData = 8'h00, rdData;
  logic dpIn = 1'b1, dmIn = 1'b1, ps2DataIn = 1'b1;
  logic pullupEn, vregEn, ppForce, openDrain, dpLevel, dmLevel, busIrq;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  busStatusReg #(.TICK_CYCLES(TICK)) dut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doWrite(logic [7:0] v, logic stbToo);
    @(negedge clk); wrEn = 1'b1; wrData = v; activityStb = stbToo;
    @(negedge clk); wrEn = 1'b0; activityStb = 1'b0;
  endtask

  task automatic setLines(logic dp, logic dm, logic ps);
    dpIn = dp; dmIn = dm; ps2DataIn = ps;
  endtask

  // drive a pattern for holdLen periods, then idle; count pulses and first latency
  task automatic runCond(logic dp, logic dm, logic ps, int holdLen,
                         output int pulses, output int lat);
    pulses = 0; lat = -1;
    @(negedge clk); setLines(dp, dm, ps);
    for (int k = 1; k <= holdLen + 3 * TICK + 6; k++) begin
      @(negedge clk);
      if (k == holdLen) setLines(1'b1, 1'b1, 1'b1);
      if (busIrq) begin
        pulses++;
        if (lat < 0) lat = k;
      end
    end
    setLines(1'b1, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int pulses, lat;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdData", rdData, 0);
    chk("R1 outputs", {pullupEn, vregEn, ppForce, openDrain, dpLevel, dmLevel, busIrq}, 0);

    // R2 R3 R11 exhaustive write sweep, activity flag low then high
    for (int a = 0; a < 2; a++) begin
      if (a == 1) begin
        @(negedge clk); activityStb = 1'b1; @(negedge clk); activityStb = 1'b0;
      end
      for (int v = 0; v < 256; v++) begin
        logic [7:0] w, exp;
        logic expDp, expDm, expPp;
        w = 8'(v) | 8'h08;          // keep bit 3 = 1 so the flag is preserved
        doWrite(w, 1'b0);
        exp = (w & 8'hE7) | (a == 1 ? 8'h08 : 8'h00);
        chk("R2 R3 readback", rdData, exp);
        chk("R2 pullup/vreg", {pullupEn, vregEn}, {w[7], w[6]});
        expPp = !w[2] && (w[1:0] != 2'b00);
        expDp = w[2] ? w[0] : (w[1:0] == 2'b01);
        expDm = w[2] ? w[1] : (w[1:0] == 2'b10);
        chk("R11 forcing", {ppForce, openDrain, dpLevel, dmLevel},
            {expPp, w[2], expDp, expDm});
      end
    end

    // R5 write 1 preserves 1, write 0 clears
    doWrite(8'h08, 1'b0);
    chk("R5 preserve", rdData[3], 1);
    doWrite(8'h00, 1'b0);
    chk("R5 clear", rdData[3], 0);
    doWrite(8'h08, 1'b0);
    chk("R5 preserve zero", rdData[3], 0);
    // R4 set and stick
    @(negedge clk); activityStb = 1'b1; @(negedge clk); activityStb = 1'b0;
    chk("R4 set", rdData[3], 1);
    repeat (10) @(negedge clk);
    chk("R4 sticky", rdData[3], 1);
    // R6 same-cycle set and clear, from 1 and from 0
    doWrite(8'h00, 1'b1);
    chk("R6 set wins from 1", rdData[3], 1);
    doWrite(8'h00, 1'b0);
    chk("R6 precondition clear", rdData[3], 0);
    doWrite(8'h00, 1'b1);
    chk("R6 set wins from 0", rdData[3], 1);

    // R7 R8 R9 sweep over modes, line patterns and tick phase
    for (int m = 0; m < 2; m++) begin
      doWrite(m == 1 ? 8'h20 : 8'h00, 1'b0);
      for (int p = 0; p < 8; p++) begin
        for (int off = 0; off < TICK; off++) begin
          logic dp, dm, ps, fire;
          dp = p[0]; dm = p[1]; ps = p[2];
          fire = (m == 0) ? (!dp && !dm) : !ps;
          repeat (off + 4) @(negedge clk);
          runCond(dp, dm, ps, 2 * TICK + 4, pulses, lat);
          chk(m == 0 ? "R7 pulse count" : "R8 pulse count", pulses, fire ? 1 : 0);
          if (fire)
            chk("R9 latency window", (lat >= TICK + 3 && lat <= 2 * TICK + 2), 1);
        end
      end
    end

    // R9 short condition never fires
    doWrite(8'h00, 1'b0);
    for (int off = 0; off < TICK; off++) begin
      repeat (off + 4) @(negedge clk);
      runCond(1'b0, 1'b0, 1'b1, TICK, pulses, lat);
      chk("R9 short hold", pulses, 0);
    end

    // R10 one pulse per long hold, and re-fire after release
    repeat (4) @(negedge clk);
    runCond(1'b0, 1'b0, 1'b1, 6 * TICK, pulses, lat);
    chk("R10 single per hold", pulses, 1);
    runCond(1'b0, 1'b0, 1'b1, 3 * TICK, pulses, lat);
    chk("R10 re-fire", pulses, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule